// File: doc/BRIEF.md
# MII Carrier Sense and Collision Generator

This block derives the carrier sense and collision indications that a 10/100 Ethernet PHY drives towards its MAC. It samples transmit activity, receive activity, a duplex select, a speed select and a heartbeat enable on a single 25 MHz clock. It presents registered `crs` and `col` outputs, one cycle after the inputs that cause them. In 10 Mb/s half duplex with the heartbeat enabled, it also plays the SQE test pulse on `col` after every transmission.

A third output, `halt_sub`, tells the downstream 100 Mb/s encoder to replace the current nibble with the HALT code when the MAC flags a transmit error. At 10 Mb/s the transmit error input has no effect.

The heartbeat is produced by a three-state machine. The states are `HB_IDLE` (no transmission tracked), `HB_TXON` (a transmission is in progress in heartbeat mode) and `HB_PULSE` (the SQE pulse is running).

The transitions are:
- `HB_IDLE -> HB_TXON` when `tx_en` is high in heartbeat mode.
- `HB_TXON -> HB_PULSE` when `tx_en` is sampled low.
- `HB_PULSE -> HB_IDLE` when the pulse count reaches its end.
- `HB_PULSE -> HB_TXON` when `tx_en` rises again, which cancels the pulse.
- Any state `-> HB_IDLE` when heartbeat mode is left, or when the duplex or speed select changes.

Top module: `mii_crs_col_gen`

## Requirements
- R1: While `rst` is high and on the cycle after it, `crs`, `col` and `halt_sub` are 0.
- R2: In half duplex (`full_dup`=0), at either speed, `crs` equals (`tx_en` OR `rx_active`) sampled one clock earlier.
- R3: In full duplex (`full_dup`=1), `crs` equals `rx_active` sampled one clock earlier, and `tx_en` alone never raises it.
- R4: In half duplex, `col` is 1 one clock after `tx_en` and `rx_active` are both sampled high.
- R5: In full duplex, `col` is 0 whatever the other inputs are.
- R6: In 10 Mb/s (`speed_100`=0) half duplex with `hb_en`=1, let the clock edge at which `tx_en` is first sampled low after a transmission be edge E. Then `col` is 0 after edge E, 1 after each of the next 25 edges, and 0 again after the edge that follows them.
- R7: No heartbeat pulse appears when `hb_en`=0, in full duplex, or at 100 Mb/s (`speed_100`=1).
- R8: If `tx_en` goes high again while the heartbeat pulse is running, the pulse is cancelled. `col` then follows only the live collision term from the second edge onward.
- R9: A change of `full_dup` or `speed_100` during the heartbeat pulse clears it. `col` is 0 from the second edge after the change.
- R10: At 100 Mb/s, `halt_sub` equals (`tx_err` AND `tx_en`) sampled one clock earlier. At 10 Mb/s, `halt_sub` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 25 MHz clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit activity from the MAC |
| tx_err | input | 1 | Transmit error request |
| rx_active | input | 1 | Receive activity from the line side |
| full_dup | input | 1 | 1 = full duplex, 0 = half duplex |
| speed_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| hb_en | input | 1 | Heartbeat (SQE test) enable |
| crs | output | 1 | Carrier sense, registered |
| col | output | 1 | Collision plus heartbeat, registered |
| halt_sub | output | 1 | Replace the current nibble with HALT |

## Verification
The internal state that can go wrong is the heartbeat machine and its pulse counter, and every error there surfaces on `col`.

- A wrong entry into `HB_PULSE` shows as `col` high one edge after the transmission ends, where it should be low.
- A miscounted pulse shows as `col` falling one edge early or late at the end of the 25-cycle window.
- A missed cancellation or mode clear leaves `col` high from the second edge after the event, where it should be low.

The directed scenarios sample `col` on every cycle of these windows, so each such fault is caught within the pulse length plus two cycles.

// File: rtl/mii_sig_pkg.sv
package mii_sig_pkg;

    typedef enum logic [1:0] {
        HB_IDLE  = 2'd0,
        HB_TXON  = 2'd1,
        HB_PULSE = 2'd2
    } hb_state_t;

endpackage

// File: rtl/sqe_heartbeat_fsm.sv
module sqe_heartbeat_fsm
    import mii_sig_pkg::*;
#(
    parameter int HB_CYCLES = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_en,
    input  logic full_dup,
    input  logic speed_100,
    input  logic hb_en,
    output logic hb_pulse
);

    localparam int CW = (HB_CYCLES > 1) ? $clog2(HB_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(HB_CYCLES - 1);

    hb_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic         fd_q, sp_q;
    logic         hb_mode, mode_chg;

    assign hb_mode  = !full_dup && !speed_100 && hb_en;
    assign mode_chg = (full_dup != fd_q) || (speed_100 != sp_q);

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!hb_mode || mode_chg) begin
            state_d = HB_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                HB_IDLE: begin
                    if (tx_en) state_d = HB_TXON;
                end
                HB_TXON: begin
                    if (!tx_en) begin
                        state_d = HB_PULSE;
                        cnt_d   = '0;
                    end
                end
                HB_PULSE: begin
                    if (tx_en) begin
                        state_d = HB_TXON;
                        cnt_d   = '0;
                    end else if (cnt_q == CNT_LAST) begin
                        state_d = HB_IDLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_d = HB_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= HB_IDLE;
            cnt_q   <= '0;
            fd_q    <= 1'b0;
            sp_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            fd_q    <= full_dup;
            sp_q    <= speed_100;
        end
    end

    // outputs
    always_comb begin
        hb_pulse = (state_q == HB_PULSE);
    end

    assert_pulse_bounded_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == HB_PULSE) |-> (cnt_q <= CNT_LAST));

    assert_pulse_mode_only_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && state_q == HB_PULSE) |-> $past(hb_mode));

    assert_cancel_on_tx_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(state_q == HB_PULSE) && $past(tx_en)) |-> (state_q != HB_PULSE));

    assert_mode_change_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode_chg)) |-> (state_q == HB_IDLE));

endmodule

// File: rtl/crs_col_out.sv
module crs_col_out (
    input  logic clk,
    input  logic rst,
    input  logic tx_en,
    input  logic tx_err,
    input  logic rx_active,
    input  logic full_dup,
    input  logic speed_100,
    input  logic hb_pulse,
    output logic crs,
    output logic col,
    output logic halt_sub
);

    logic crs_d, col_d, halt_d;

    always_comb begin
        crs_d  = full_dup ? rx_active : (tx_en | rx_active);
        col_d  = full_dup ? 1'b0 : ((tx_en & rx_active) | hb_pulse);
        halt_d = speed_100 & tx_err & tx_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            crs      <= 1'b0;
            col      <= 1'b0;
            halt_sub <= 1'b0;
        end else begin
            crs      <= crs_d;
            col      <= col_d;
            halt_sub <= halt_d;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (!crs && !col && !halt_sub));

    assert_hd_crs_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(full_dup)) |-> (crs == $past(tx_en | rx_active)));

    assert_fd_crs_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(full_dup)) |-> (crs == $past(rx_active)));

    assert_hd_col_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(full_dup) && $past(tx_en && rx_active)) |-> col);

    assert_fd_col_low_R5: assert property (@(posedge clk) disable iff (rst)
        $past(full_dup) |-> !col);

    assert_halt_10m_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(speed_100)) |-> !halt_sub);

endmodule

// File: rtl/mii_crs_col_gen.sv
module mii_crs_col_gen #(
    parameter int HB_CYCLES = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_en,
    input  logic tx_err,
    input  logic rx_active,
    input  logic full_dup,
    input  logic speed_100,
    input  logic hb_en,
    output logic crs,
    output logic col,
    output logic halt_sub
);

    logic hb_pulse;

    sqe_heartbeat_fsm #(.HB_CYCLES(HB_CYCLES)) u_hb (
        .clk       (clk),
        .rst       (rst),
        .tx_en     (tx_en),
        .full_dup  (full_dup),
        .speed_100 (speed_100),
        .hb_en     (hb_en),
        .hb_pulse  (hb_pulse)
    );

    crs_col_out u_out (
        .clk       (clk),
        .rst       (rst),
        .tx_en     (tx_en),
        .tx_err    (tx_err),
        .rx_active (rx_active),
        .full_dup  (full_dup),
        .speed_100 (speed_100),
        .hb_pulse  (hb_pulse),
        .crs       (crs),
        .col       (col),
        .halt_sub  (halt_sub)
    );

endmodule

// File: tb/mii_crs_col_gen_bench.sv
module mii_crs_col_gen_bench;

    localparam int CLK_PERIOD = 40;
    localparam int HB_LEN     = 25;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_en = 1'b0, tx_err = 1'b0, rx_active = 1'b0;
    logic full_dup = 1'b0, speed_100 = 1'b0, hb_en = 1'b0;
    logic crs, col, halt_sub;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mii_crs_col_gen #(.HB_CYCLES(HB_LEN)) u_mii_crs_col_gen (
        .clk(clk), .rst(rst), .tx_en(tx_en), .tx_err(tx_err),
        .rx_active(rx_active), .full_dup(full_dup), .speed_100(speed_100),
        .hb_en(hb_en), .crs(crs), .col(col), .halt_sub(halt_sub)
    );

    task automatic cycle();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic set_in(input logic t, input logic r, input logic e);
        tx_en = t; rx_active = r; tx_err = e;
    endtask

    task automatic test_reset();
        rst = 1'b1;
        set_in(1, 1, 1);
        speed_100 = 1'b1;
        cycle(); cycle();
        chk("R1", "crs in reset", crs, 1'b0);
        chk("R1", "col in reset", col, 1'b0);
        chk("R1", "halt in reset", halt_sub, 1'b0);
        set_in(0, 0, 0);
        speed_100 = 1'b0;
        rst = 1'b0;
        cycle();
        chk("R1", "crs after reset", crs, 1'b0);
    endtask

    task automatic test_half_duplex();
        full_dup = 1'b0; hb_en = 1'b0;
        for (int sp = 0; sp < 2; sp++) begin
            speed_100 = sp[0];
            for (int p = 0; p < 4; p++) begin
                set_in(p[0], p[1], 0);
                cycle();
                chk("R2", "hd crs", crs, p[0] | p[1]);
                chk("R4", "hd col", col, p[0] & p[1]);
            end
        end
        set_in(0, 0, 0); speed_100 = 1'b0;
        cycle(); cycle();
    endtask

    task automatic test_full_duplex();
        full_dup = 1'b1; hb_en = 1'b1;
        for (int sp = 0; sp < 2; sp++) begin
            speed_100 = sp[0];
            for (int p = 0; p < 4; p++) begin
                set_in(p[0], p[1], 0);
                cycle();
                chk("R3", "fd crs", crs, p[1]);
                chk("R5", "fd col", col, 1'b0);
            end
        end
        set_in(0, 0, 0); full_dup = 1'b0; speed_100 = 1'b0; hb_en = 1'b0;
        cycle(); cycle();
    endtask

    task automatic test_heartbeat();
        full_dup = 1'b0; speed_100 = 1'b0; hb_en = 1'b1;
        cycle(); cycle();
        set_in(1, 0, 0);
        repeat (4) cycle();
        set_in(0, 0, 0);
        cycle();
        chk("R6", "col at tx end", col, 1'b0);
        for (int i = 0; i < HB_LEN; i++) begin
            cycle();
            chk("R6", $sformatf("col pulse cycle %0d", i), col, 1'b1);
        end
        cycle();
        chk("R6", "col after pulse", col, 1'b0);
        cycle();
        chk("R6", "col stays low", col, 1'b0);
    endtask

    task automatic no_pulse_run(input string tag, input logic fd, input logic sp, input logic he);
        int highs = 0;
        full_dup = fd; speed_100 = sp; hb_en = he;
        cycle(); cycle();
        set_in(1, 0, 0);
        repeat (4) cycle();
        set_in(0, 0, 0);
        for (int i = 0; i < HB_LEN + 4; i++) begin
            cycle();
            if (col) highs++;
        end
        chk("R7", tag, highs != 0, 1'b0);
    endtask

    task automatic test_no_heartbeat();
        no_pulse_run("no pulse hb_en=0", 0, 0, 0);
        no_pulse_run("no pulse full duplex", 1, 0, 1);
        no_pulse_run("no pulse 100M", 0, 1, 1);
        full_dup = 1'b0; speed_100 = 1'b0; hb_en = 1'b0;
        cycle();
    endtask

    task automatic test_cancel();
        int highs = 0;
        full_dup = 1'b0; speed_100 = 1'b0; hb_en = 1'b1;
        cycle(); cycle();
        set_in(1, 0, 0);
        repeat (3) cycle();
        set_in(0, 0, 0);
        repeat (6) cycle();
        chk("R8", "pulse running before cancel", col, 1'b1);
        set_in(1, 0, 0);
        cycle();
        cycle();
        chk("R8", "col after cancel", col, 1'b0);
        for (int i = 0; i < HB_LEN; i++) begin
            cycle();
            if (col) highs++;
        end
        chk("R8", "col stays low during new tx", highs != 0, 1'b0);
        set_in(1, 1, 0);
        cycle();
        chk("R8", "live collision after cancel", col, 1'b1);
        set_in(0, 0, 0); hb_en = 1'b0;
        repeat (3) cycle();
    endtask

    task automatic test_mode_change();
        int highs = 0;
        full_dup = 1'b0; speed_100 = 1'b0; hb_en = 1'b1;
        cycle(); cycle();
        set_in(1, 0, 0);
        repeat (3) cycle();
        set_in(0, 0, 0);
        repeat (5) cycle();
        chk("R9", "pulse running before change", col, 1'b1);
        speed_100 = 1'b1;
        cycle();
        speed_100 = 1'b0;
        cycle();
        chk("R9", "col after speed change", col, 1'b0);
        for (int i = 0; i < HB_LEN; i++) begin
            cycle();
            if (col) highs++;
        end
        chk("R9", "pulse not resumed", highs != 0, 1'b0);
        hb_en = 1'b0;
        cycle();
    endtask

    task automatic test_halt();
        full_dup = 1'b0;
        speed_100 = 1'b1;
        for (int p = 0; p < 4; p++) begin
            set_in(p[0], 0, p[1]);
            cycle();
            chk("R10", "halt 100M", halt_sub, p[0] & p[1]);
        end
        speed_100 = 1'b0;
        set_in(1, 0, 1);
        cycle();
        chk("R10", "halt ignored at 10M", halt_sub, 1'b0);
        cycle();
        chk("R10", "halt ignored at 10M hold", halt_sub, 1'b0);
        set_in(0, 0, 0);
        cycle();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #1;
        test_reset();
        test_half_duplex();
        test_full_duplex();
        test_heartbeat();
        test_no_heartbeat();
        test_cancel();
        test_mode_change();
        test_halt();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule